// File: doc/BRIEF.md
# Two-Source Byte Shuffle Unit

This unit assembles a 128-bit result from sixteen byte lanes. Each lane is chosen on its own from a 32-byte pool made by placing two 128-bit source operands side by side. A third 128-bit operand, the control vector, carries one selector byte per result lane. The selector steers that lane's 32-way choice. One lane's choice does not depend on any other lane's choice.

Byte lanes are numbered big-endian: lane 0 occupies bits 127:120. Pool bytes 0 to 15 are the first source in that numbering. Pool bytes 16 to 31 are the second source, so pool byte 16 is bits 127:120 of the second source.

The shuffled value passes through one register stage. A valid strobe travels through the same stage alongside it. A caller presents the operands with the strobe high and reads the result one clock later.

Top module: `byte_shuffle_unit`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is low, `out_valid` is 0 and `out_data` is all zeros.
- R2: A selector value s in 0..15 places byte s of `src_a` into the result lane, where byte s is bits [127-8s -: 8].
- R3: A selector value s in 16..31 places byte s-16 of `src_b` into the result lane, where byte s-16 is bits [127-8(s-16) -: 8].
- R4: Only the low 5 bits of each selector byte are used. The upper 3 bits have no effect on the result.
- R5: `out_valid` is high one clock after a cycle with `in_valid` high, and low one clock after a cycle with `in_valid` low. `out_data` holds the result of the operands presented in that earlier cycle.
- R6: When `in_valid` is low, `out_data` keeps its previous value, whatever the operand inputs carry.
- R7: When the selector bytes are 0,1,...,15 in lane order, `out_data` equals `src_a` unchanged.
- R8: Each lane is selected independently of the others. Several lanes may name the same pool byte, and back-to-back valid inputs each produce their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| src_a | input | 128 | First source, pool bytes 0..15 |
| src_b | input | 128 | Second source, pool bytes 16..31 |
| ctl | input | 128 | One selector byte per result lane |
| out_valid | output | 1 | Registered valid |
| out_data | output | 128 | Registered shuffled result |

## Verification
The identity selector pattern confirms that lane numbering and byte order are not mirrored, because a mirrored layout would reverse `src_a`. The reversed pattern and the pattern that selects only from the second source separate the two halves of the pool. They also show whether the half boundary sits at selector 16. Selectors that name a single pool byte in every lane, and the same patterns with junk in the upper selector bits, show that lanes are independent and that bits 7:5 are dropped. Runs of random operands, mixed with idle cycles that change the inputs, check the one-cycle alignment and that the result holds while `in_valid` is low.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

  // Reduce a selector byte to a pool index; modulo keeps only the low bits.
  function automatic int unsigned pool_index(input logic [7:0] sel_byte,
                                             input int unsigned pool_bytes);
    return int'(sel_byte) % pool_bytes;
  endfunction

endpackage

// File: rtl/shuf_lane_mux.sv
module shuf_lane_mux #(
  parameter int POOL_BYTES = 32,
  parameter int BYTE_W     = 8
) (
  input  logic [POOL_BYTES*BYTE_W-1:0] pool,
  input  logic [BYTE_W-1:0]            sel_byte,
  output logic [BYTE_W-1:0]            lane_out,
  output logic                         from_second
);
  localparam int HALF = POOL_BYTES / 2;

  int unsigned idx;

  always_comb begin
    idx         = shuf_pkg::pool_index(8'(sel_byte), POOL_BYTES);
    from_second = (idx >= HALF);
    // pool byte 0 is the most significant byte of the pool
    lane_out    = pool[(POOL_BYTES-1-idx)*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/shuf_out_reg.sv
module shuf_out_reg #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         vld_q,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      q     <= '0;
    end else begin
      vld_q <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit #(
  parameter int VEC_BYTES = 16,
  parameter int BYTE_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [VEC_BYTES*BYTE_W-1:0]    src_a,
  input  logic [VEC_BYTES*BYTE_W-1:0]    src_b,
  input  logic [VEC_BYTES*BYTE_W-1:0]    ctl,
  output logic                           out_valid,
  output logic [VEC_BYTES*BYTE_W-1:0]    out_data
);
  localparam int VEC_W      = VEC_BYTES * BYTE_W;
  localparam int POOL_BYTES = 2 * VEC_BYTES;
  localparam int POOL_W     = POOL_BYTES * BYTE_W;

  logic [POOL_W-1:0]    pool;
  logic [VEC_W-1:0]     shuffled;
  logic [VEC_BYTES-1:0] lane_from_b;  // named event wires for observation
  logic                 capture;

  assign pool    = {src_a, src_b};
  assign capture = in_valid;

  for (genvar ln = 0; ln < VEC_BYTES; ln++) begin : g_lane
    shuf_lane_mux #(
      .POOL_BYTES(POOL_BYTES),
      .BYTE_W    (BYTE_W)
    ) u_mux (
      .pool       (pool),
      .sel_byte   (ctl[VEC_W-1-ln*BYTE_W -: BYTE_W]),
      .lane_out   (shuffled[VEC_W-1-ln*BYTE_W -: BYTE_W]),
      .from_second(lane_from_b[ln])
    );
  end

  shuf_out_reg #(.W(VEC_W)) u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .load (capture),
    .d    (shuffled),
    .vld_q(out_valid),
    .q    (out_data)
  );

endmodule

// File: rtl/shuf_checker.sv
module shuf_checker #(
  parameter int VEC_BYTES = 16,
  parameter int BYTE_W    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic [VEC_BYTES*BYTE_W-1:0] src_a,
  input logic [VEC_BYTES*BYTE_W-1:0] ctl,
  input logic                        out_valid,
  input logic [VEC_BYTES*BYTE_W-1:0] out_data
);
  localparam int VEC_W = VEC_BYTES * BYTE_W;

  function automatic logic is_identity(input logic [VEC_W-1:0] c);
    logic ok = 1'b1;
    for (int i = 0; i < VEC_BYTES; i++)
      if (c[VEC_W-1-i*BYTE_W -: BYTE_W] != BYTE_W'(i)) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic all_low_zero(input logic [VEC_W-1:0] c);
    logic ok = 1'b1;
    for (int i = 0; i < VEC_BYTES; i++)
      if (c[VEC_W-1-i*BYTE_W -: BYTE_W] % (2*VEC_BYTES) != 0) ok = 1'b0;
    return ok;
  endfunction

  p_valid_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  p_identity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_identity(ctl)) |=> (out_data == $past(src_a)));
  p_upper_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && all_low_zero(ctl)) |=>
      (out_data == {VEC_BYTES{$past(src_a[VEC_W-1 -: BYTE_W])}}));

endmodule

bind byte_shuffle_unit shuf_checker #(
  .VEC_BYTES(VEC_BYTES),
  .BYTE_W   (BYTE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .src_a    (src_a),
  .ctl      (ctl),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/test_byte_shuffle_unit.sv
module test_byte_shuffle_unit;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         in_valid = 0;
  logic [127:0] src_a = '0, src_b = '0, ctl = '0;
  logic         out_valid;
  logic [127:0] out_data;

  int n_cmp = 0, n_bad = 0;
  logic [127:0] exp_q[$];
  string        tag_q[$];
  logic [127:0] last_out = '0;
  bit           done = 0;

  always #4 clk = ~clk;

  byte_shuffle_unit i_byte_shuffle_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .ctl(ctl),
    .out_valid(out_valid), .out_data(out_data)
  );

  // Reference: shift the chosen source so the wanted byte lands at the bottom
  function automatic logic [127:0] ref_shuffle(logic [127:0] a, logic [127:0] b,
                                               logic [127:0] c);
    logic [127:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      logic [7:0]   s = c[8*(15-i) +: 8] & 8'h1f;
      logic [127:0] w = (s < 16) ? a : b;
      w = w >> (8 * (15 - (s & 8'h0f)));
      r[8*(15-i) +: 8] = w[7:0];
    end
    return r;
  endfunction

  function automatic logic [127:0] sel_vec(input int base, input int step,
                                           input logic [7:0] hi);
    logic [127:0] c;
    for (int i = 0; i < 16; i++) c[127-8*i -: 8] = hi | 8'((base + step*i) & 31);
    return c;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [127:0] a, logic [127:0] b, logic [127:0] c, string req);
    @(negedge clk);
    in_valid = 1; src_a = a; src_b = b; ctl = c;
    exp_q.push_back(ref_shuffle(a, b, c));
    tag_q.push_back(req);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0; src_a = rnd128(); src_b = rnd128(); ctl = rnd128();
    end
  endtask

  // Monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R5: out_valid high with nothing expected (got 1 expected 0)");
        end else begin
          string t = tag_q.pop_front();
          check(t, out_data, exp_q.pop_front());
        end
      end else begin
        check("R6 hold", out_data, last_out);
      end
      last_out = out_data;
    end
  end

  localparam logic [127:0] A0 = 128'h00112233_44556677_8899aabb_ccddeeff;
  localparam logic [127:0] B0 = 128'hf0e1d2c3_b4a59687_78695a4b_3c2d1e0f;

  initial begin
    #20;
    check("R1 reset data", out_data, '0);
    n_cmp++;
    if (out_valid !== 1'b0) begin
      n_bad++; $display("FAIL R1: out_valid got %b expected 0", out_valid);
    end
    @(negedge clk); rst_n = 1;
    idle(2);
    drive(A0, B0, sel_vec(0, 1, 8'h00), "R7 identity");
    check("R7 identity ref", ref_shuffle(A0, B0, sel_vec(0, 1, 8'h00)), A0);
    drive(A0, B0, sel_vec(15, -1, 8'h00), "R2 reversed src_a");
    drive(A0, B0, sel_vec(16, 1, 8'h00), "R3 src_b in order");
    drive(A0, B0, sel_vec(31, -1, 8'h00), "R3 src_b reversed");
    drive(A0, B0, sel_vec(16, 0, 8'h00), "R3 broadcast byte 16");
    drive(A0, B0, sel_vec(31, 0, 8'h00), "R8 broadcast byte 31");
    drive(A0, B0, sel_vec(0, 2, 8'h00), "R8 interleave");
    idle(3);
    drive(A0, B0, sel_vec(0, 1, 8'he0), "R4 identity upper bits set");
    drive(A0, B0, sel_vec(0, 0, 8'he0), "R4 selector 0xE0");
    drive(A0, B0, sel_vec(16, 1, 8'ha0), "R4 src_b upper bits set");
    idle(4);
    for (int k = 0; k < 40; k++) begin
      drive(rnd128(), rnd128(), rnd128(), "R8 random");
      if (k % 7 == 3) idle(2);
    end
    idle(3);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++; $display("FAIL R5: %0d results missing (expected 0)", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung (got timeout expected completion)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule